// File: doc/BRIEF.md
# Serial interrupt host controller

This block is the host end of a one-wire serialized interrupt bus that runs on the PCI clock. Each bus cycle opens with a low start pulse and a one-clock recovery and a one-clock turnaround. A run of three-clock data frames follows (sample, recovery, turnaround). In each frame one slave may pull the line low during the sample clock to signal its interrupt. The cycle closes with a low stop pulse. The width of that stop pulse tells every agent which mode the next cycle uses.

In Continuous mode, which is the mode after reset, only the host starts cycles, and it starts each one directly after the previous stop turnaround. In Quiet mode the line rests released between cycles. A new cycle then begins when a slave pulls the line low for one clock, and the host completes the start pulse. It also begins when the host has a local request pending. The shared line is modelled as a sampled input together with output-enable and output-value signals. The start-pulse width and the number of frames are setting inputs. The sampled slot levels are presented as interrupt-request outputs, with one further output for the IOCHCK# slot.

Top module: `sirq_host`

## Requirements
- R1: While rst_n is low and after it is released, the block is in Continuous mode (quiet_mode = 0). It does not drive the line (line_oe = 0), and irq_level and iochck_level are all 0.
- R2: In Continuous mode the host starts a cycle without any request. After a stop frame that selects Continuous mode, it drives the next start pulse low in the clock right after the stop turnaround clock.
- R3: A host-started start pulse drives the line low (line_oe = 1, line_out = 0) for start_width clocks, with values below 4 taken as 4 and values above 8 taken as 8. The host then drives the line high (line_oe = 1, line_out = 1) for one clock and releases it (line_oe = 0) for one turnaround clock.
- R4: In Quiet mode, when the line is released and idle and reads low for one clock, the host drives it low for the clamped start_width minus one further clocks. The cycle then continues as in R3.
- R5: In Quiet mode an idle host with cycle_req high starts a cycle with the full start pulse. With cycle_req low and the line high, the line stays released and the outputs keep their values.
- R6: After the start turnaround the host runs frame_count data frames of three released clocks each. frame_count 0 is taken as 1 and values above MAX_FRAMES are taken as MAX_FRAMES. The host then starts the stop pulse, so 1 + 3 x frames released clocks separate the start recovery clock from the stop pulse.
- R7: The line level is sampled in the first clock of frame k, counting from 0. For k < 16 a low level sets irq_level[k] to 1 and a high level sets it to 0. Frame 16 updates iochck_level the same way. Frames that a cycle does not run leave their outputs unchanged, and frames beyond 16 affect no output.
- R8: The stop pulse is driven low for 2 clocks when quiet_sel is 1 at its start and for 3 clocks when quiet_sel is 0. It is followed by one driven-high clock and one released turnaround clock.
- R9: quiet_mode changes only after a stop turnaround clock. It then equals 1 after a 2-clock stop pulse and 0 after a 3-clock stop pulse.
- R10: A start pulse begins only from the idle state or directly after a stop turnaround. cycle_req or low line levels during an active cycle do not change its frame count or pulse widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Sampled level of the shared line |
| line_oe | output | 1 | Host drives the line when 1 |
| line_out | output | 1 | Level the host drives when line_oe is 1 |
| quiet_sel | input | 1 | Mode the next stop pulse selects: 1 Quiet, 0 Continuous |
| cycle_req | input | 1 | Local request for a cycle in Quiet mode |
| start_width | input | SW_W | Start pulse width in clocks, clamped to 4..8 |
| frame_count | input | FC_W | Number of data frames per cycle, clamped to 1..MAX_FRAMES |
| quiet_mode | output | 1 | Current bus mode: 1 Quiet, 0 Continuous |
| irq_level | output | NUM_IRQ | Interrupt levels, 1 = slot sampled low |
| iochck_level | output | 1 | IOCHCK# slot level, 1 = sampled low |

## Verification
The bench builds the block with its defaults: NUM_IRQ 16, MAX_FRAMES 24 and a 4-bit start width, which gives a 5-bit frame count. The 4-bit width field lets it request pulses of 2 and 15 and so reach both start-width clamps. The 5-bit count lets it ask for 0 and for 30 frames, which reaches both frame clamps. It also runs frames past the IOCHCK# slot and short cycles that leave upper slots untouched.

// File: rtl/sirq_pkg.sv
// Shared definitions for the serial interrupt host controller.
// Assumes: one bus clock domain; all users import this package.
package sirq_pkg;

    // Host sequencer states, one per bus phase.
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_SREC  = 4'd2,
        ST_STA   = 4'd3,
        ST_SAMP  = 4'd4,
        ST_RECOV = 4'd5,
        ST_TURN  = 4'd6,
        ST_STOP  = 4'd7,
        ST_PREC  = 4'd8,
        ST_PTA   = 4'd9
    } sirq_state_e;

    localparam int unsigned START_MIN  = 4;
    localparam int unsigned START_MAX  = 8;
    localparam int unsigned STOP_QUIET = 2;
    localparam int unsigned STOP_CONT  = 3;

endpackage

// File: rtl/sirq_seq.sv
// Cycle sequencer: steps the bus through start, data frames and stop,
// decides when a cycle may begin and holds the current bus mode.
// Assumes: line_in is already synchronous to clk; CNT_W can hold 8.
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 24,
    parameter int SW_W       = 4,
    parameter int FC_W       = 5,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              quiet_sel,
    input  logic              cycle_req,
    input  logic [SW_W-1:0]   start_width,
    input  logic [FC_W-1:0]   frame_count,
    output sirq_state_e       state,
    output logic [FC_W-1:0]   slot,
    output logic              quiet_mode
);

    sirq_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [FC_W-1:0]  slot_q, slot_d;
    logic [FC_W-1:0]  last_q, last_d;
    logic             stopq_q, stopq_d;
    logic             mode_q, mode_d;
    logic [CNT_W-1:0] sw_cl;
    logic [FC_W-1:0]  fc_cl;

    // Clamp the start-pulse width into the legal window.
    always_comb begin
        if (start_width < SW_W'(START_MIN))
            sw_cl = CNT_W'(START_MIN);
        else if (start_width > SW_W'(START_MAX))
            sw_cl = CNT_W'(START_MAX);
        else
            sw_cl = CNT_W'(start_width);
    end

    // Clamp the frame count into 1..MAX_FRAMES.
    always_comb begin
        if (frame_count == '0)
            fc_cl = FC_W'(1);
        else if (frame_count > FC_W'(MAX_FRAMES))
            fc_cl = FC_W'(MAX_FRAMES);
        else
            fc_cl = frame_count;
    end

    // Next-state and counter logic for the bus phases.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        slot_d  = slot_q;
        last_d  = last_q;
        stopq_d = stopq_q;
        mode_d  = mode_q;
        case (state_q)
            ST_IDLE: begin
                if (!mode_q) begin
                    state_d = ST_START;
                    cnt_d   = sw_cl;
                    last_d  = fc_cl - FC_W'(1);
                end else if (!line_in) begin
                    state_d = ST_START;
                    cnt_d   = sw_cl - CNT_W'(1);
                    last_d  = fc_cl - FC_W'(1);
                end else if (cycle_req) begin
                    state_d = ST_START;
                    cnt_d   = sw_cl;
                    last_d  = fc_cl - FC_W'(1);
                end
            end
            ST_START: begin
                if (cnt_q <= CNT_W'(1))
                    state_d = ST_SREC;
                else
                    cnt_d = cnt_q - CNT_W'(1);
            end
            ST_SREC:  state_d = ST_STA;
            ST_STA: begin
                state_d = ST_SAMP;
                slot_d  = '0;
            end
            ST_SAMP:  state_d = ST_RECOV;
            ST_RECOV: state_d = ST_TURN;
            ST_TURN: begin
                if (slot_q == last_q) begin
                    state_d = ST_STOP;
                    stopq_d = quiet_sel;
                    cnt_d   = quiet_sel ? CNT_W'(STOP_QUIET) : CNT_W'(STOP_CONT);
                end else begin
                    state_d = ST_SAMP;
                    slot_d  = slot_q + FC_W'(1);
                end
            end
            ST_STOP: begin
                if (cnt_q <= CNT_W'(1))
                    state_d = ST_PREC;
                else
                    cnt_d = cnt_q - CNT_W'(1);
            end
            ST_PREC:  state_d = ST_PTA;
            ST_PTA: begin
                mode_d = stopq_q;
                if (stopq_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_START;
                    cnt_d   = sw_cl;
                    last_d  = fc_cl - FC_W'(1);
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers with synchronous reset into Continuous idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            slot_q  <= '0;
            last_q  <= '0;
            stopq_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slot_q  <= slot_d;
            last_q  <= last_d;
            stopq_q <= stopq_d;
            mode_q  <= mode_d;
        end
    end

    assign state      = state_q;
    assign slot       = slot_q;
    assign quiet_mode = mode_q;

endmodule

// File: rtl/sirq_capture.sv
// Slot capture: holds one level per interrupt slot plus the IOCHCK#
// slot, each written when its frame's sample clock ends.
// Assumes: slot index width can express NUM_IRQ.
module sirq_capture #(
    parameter int NUM_IRQ = 16,
    parameter int FC_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en,
    input  logic [FC_W-1:0]    slot,
    input  logic               line_in,
    output logic [NUM_IRQ-1:0] irq_level,
    output logic               iochck_level
);

    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_slot
            // Store the inverted line level when this slot is sampled.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    irq_level[g] <= 1'b0;
                else if (sample_en && slot == FC_W'(g))
                    irq_level[g] <= ~line_in;
            end
        end
    endgenerate

    // Store the IOCHCK# slot, which follows the last interrupt slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            iochck_level <= 1'b0;
        else if (sample_en && slot == FC_W'(NUM_IRQ))
            iochck_level <= ~line_in;
    end

endmodule

// File: rtl/sirq_drive.sv
// Line driver decode: turns the sequencer phase into the host's
// output-enable and driven level.
// Assumes: the line is pulled high whenever nobody drives it.
module sirq_drive
    import sirq_pkg::*;
(
    input  sirq_state_e state,
    output logic        line_oe,
    output logic        line_out
);

    // Drive low in pulse phases, high in recovery, release elsewhere.
    always_comb begin
        line_oe  = 1'b0;
        line_out = 1'b1;
        case (state)
            ST_START, ST_STOP: begin
                line_oe  = 1'b1;
                line_out = 1'b0;
            end
            ST_SREC, ST_PREC: begin
                line_oe  = 1'b1;
                line_out = 1'b1;
            end
            default: begin
                line_oe  = 1'b0;
                line_out = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sirq_host.sv
// Serial interrupt host controller top: sequencer, slot capture and
// line driver. Assumes MAX_FRAMES >= NUM_IRQ + 1 and SW_W >= 4.
module sirq_host
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ    = 16,
    parameter int MAX_FRAMES = 24,
    parameter int SW_W       = 4,
    parameter int FC_W       = $clog2(MAX_FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_in,
    output logic               line_oe,
    output logic               line_out,
    input  logic               quiet_sel,
    input  logic               cycle_req,
    input  logic [SW_W-1:0]    start_width,
    input  logic [FC_W-1:0]    frame_count,
    output logic               quiet_mode,
    output logic [NUM_IRQ-1:0] irq_level,
    output logic               iochck_level
);

    localparam int CNT_W = SW_W;

    sirq_state_e     seq_state;
    logic [FC_W-1:0] seq_slot;
    logic            sample_en;

    assign sample_en = (seq_state == ST_SAMP);

    sirq_seq #(
        .MAX_FRAMES(MAX_FRAMES),
        .SW_W(SW_W),
        .FC_W(FC_W),
        .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .line_in(line_in),
        .quiet_sel(quiet_sel),
        .cycle_req(cycle_req),
        .start_width(start_width),
        .frame_count(frame_count),
        .state(seq_state),
        .slot(seq_slot),
        .quiet_mode(quiet_mode)
    );

    sirq_capture #(
        .NUM_IRQ(NUM_IRQ),
        .FC_W(FC_W)
    ) u_cap (
        .clk(clk),
        .rst_n(rst_n),
        .sample_en(sample_en),
        .slot(seq_slot),
        .line_in(line_in),
        .irq_level(irq_level),
        .iochck_level(iochck_level)
    );

    sirq_drive u_drv (
        .state(seq_state),
        .line_oe(line_oe),
        .line_out(line_out)
    );

endmodule

// File: rtl/sirq_host_chk.sv
// Property checker for sirq_host, attached through bind.
// Assumes: it sees the top's ports plus the sequencer phase and slot.
module sirq_host_chk
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int FC_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_in,
    input logic               line_oe,
    input logic               line_out,
    input logic               cycle_req,
    input logic               quiet_mode,
    input logic [NUM_IRQ-1:0] irq_level,
    input sirq_state_e        state,
    input logic [FC_W-1:0]    slot_idx
);

    localparam int IW = $clog2(NUM_IRQ);

    logic [3:0]    low_run;
    logic [3:0]    stop_run;
    logic [IW-1:0] samp_slot;
    logic          samp_val;

    // Count consecutive clocks in which the host drives the line low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (line_oe && !line_out)
            low_run <= (low_run == 4'hF) ? low_run : low_run + 4'd1;
        else
            low_run <= '0;
    end

    // Remember the stop width and the latest sampled slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_run  <= '0;
            samp_slot <= '0;
            samp_val  <= 1'b0;
        end else begin
            if (state == ST_PREC)
                stop_run <= low_run;
            samp_slot <= slot_idx[IW-1:0];
            samp_val  <= ~line_in;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!line_oe && !quiet_mode && irq_level == '0));

    p_cont_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTA) |=> (quiet_mode || (line_oe && !line_out)));

    p_start_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SREC) |-> (low_run >= 4'd3 && low_run <= 4'd8));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && quiet_mode && line_in && !cycle_req) |=> (state == ST_IDLE));

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMP && slot_idx < FC_W'(NUM_IRQ)) |=> (irq_level[samp_slot] == samp_val));

    p_stop_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREC) |-> (low_run == 4'd2 || low_run == 4'd3));

    p_mode_from_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTA) |=> (quiet_mode == (stop_run == 4'd2)));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quiet_mode) |-> ($past(state) == ST_PTA));

    p_start_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START)
            |-> ($past(state) == ST_IDLE || $past(state) == ST_PTA));

endmodule

bind sirq_host sirq_host_chk #(
    .NUM_IRQ(NUM_IRQ),
    .FC_W(FC_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .line_in(line_in),
    .line_oe(line_oe),
    .line_out(line_out),
    .cycle_req(cycle_req),
    .quiet_mode(quiet_mode),
    .irq_level(irq_level),
    .state(seq_state),
    .slot_idx(seq_slot)
);

// File: tb/tb_sirq_host.sv
`timescale 1ns/1ps
// Scoreboard bench: run_cycle plays the slaves and queues the expected
// cycle outcome; a monitor measures the bus and compares at cycle end.
module tb_sirq_host;

    localparam int NUM_IRQ    = 16;
    localparam int MAX_FRAMES = 24;
    localparam int SW_W       = 4;
    localparam int FC_W       = 5;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               line_in;
    logic               line_oe;
    logic               line_out;
    logic               quiet_sel;
    logic               cycle_req;
    logic [SW_W-1:0]    start_width;
    logic [FC_W-1:0]    frame_count;
    logic               quiet_mode;
    logic [NUM_IRQ-1:0] irq_level;
    logic               iochck_level;
    logic               slave_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        int start_low;
        int mid;
        int stop_low;
        int irq;
        int ioc;
        int mode;
    } item_t;

    item_t exp_q[$];
    logic [NUM_IRQ-1:0] m_irq;
    logic               m_ioc;

    always #2.5 clk = ~clk;

    // Wired bus with pull-up: host drive wins, else a slave may pull low.
    assign line_in = line_oe ? line_out : ~slave_low;

    sirq_host #(
        .NUM_IRQ(NUM_IRQ),
        .MAX_FRAMES(MAX_FRAMES),
        .SW_W(SW_W),
        .FC_W(FC_W)
    ) dut (
        .clk(clk),
        .rst_n(rst_n),
        .line_in(line_in),
        .line_oe(line_oe),
        .line_out(line_out),
        .quiet_sel(quiet_sel),
        .cycle_req(cycle_req),
        .start_width(start_width),
        .frame_count(frame_count),
        .quiet_mode(quiet_mode),
        .irq_level(irq_level),
        .iochck_level(iochck_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // how: 0 host start in Continuous, 1 slave start, 2 local request.
    task automatic run_cycle(input int how, input logic [23:0] pat,
                             input bit qnext, input int sw, input int fc);
        item_t it;
        int swc, fcc;
        swc = (sw < 4) ? 4 : (sw > 8) ? 8 : sw;
        fcc = (fc < 1) ? 1 : (fc > MAX_FRAMES) ? MAX_FRAMES : fc;
        for (int k = 0; k < fcc; k++) begin
            if (k < NUM_IRQ) m_irq[k] = pat[k];
            else if (k == NUM_IRQ) m_ioc = pat[k];
        end
        it.start_low = (how == 1) ? swc - 1 : swc;
        it.mid       = 1 + 3 * fcc;
        it.stop_low  = qnext ? 2 : 3;
        it.irq       = int'(m_irq);
        it.ioc       = int'(m_ioc);
        it.mode      = int'(qnext);
        exp_q.push_back(it);
        start_width = SW_W'(sw);
        frame_count = FC_W'(fc);
        quiet_sel   = qnext;
        if (how == 1) begin
            @(negedge clk);
            slave_low = 1'b1;
            @(negedge clk);
            slave_low = 1'b0;
        end else if (how == 2) begin
            @(negedge clk);
            cycle_req = 1'b1;
        end
        do @(negedge clk); while (!(line_oe && line_out));
        @(negedge clk);
        for (int k = 0; k < fcc; k++) begin
            @(negedge clk);
            slave_low = pat[k];
            @(negedge clk);
            slave_low = 1'b0;
            @(negedge clk);
        end
        do @(negedge clk); while (!(line_oe && !line_out));
        cycle_req = 1'b0;
        do @(negedge clk); while (!(line_oe && line_out));
        @(negedge clk);
    endtask

    // Monitor: measure pulse widths and frame span, compare at cycle end.
    int ph = 0, cnt = 0, mid = 0, s_low = 0, p_low = 0;
    always @(negedge clk) begin
        item_t it;
        bit drv_lo, drv_hi;
        if (!rst_n) begin
            ph = 0;
        end else begin
            drv_lo = line_oe && !line_out;
            drv_hi = line_oe && line_out;
            if (ph == 5) begin
                if (exp_q.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R6 actual=unexpected cycle expected=none");
                end else begin
                    it = exp_q.pop_front();
                    chk("R3/R4 start low width", s_low, it.start_low);
                    chk("R6 released clocks to stop", mid, it.mid);
                    chk("R8 stop low width", p_low, it.stop_low);
                    chk("R7 irq_level", int'(irq_level), it.irq);
                    chk("R7 iochck_level", int'(iochck_level), it.ioc);
                    chk("R9 quiet_mode after stop", int'(quiet_mode), it.mode);
                    if (it.mode == 0)
                        chk("R2 immediate restart", int'(drv_lo), 1);
                end
                ph = 0;
            end
            case (ph)
                0: if (drv_lo) begin ph = 1; cnt = 1; end
                1: if (drv_lo) cnt++;
                   else if (drv_hi) begin s_low = cnt; ph = 2; mid = 0; end
                2: if (!line_oe) mid++;
                   else if (drv_lo) begin ph = 3; cnt = 1; end
                3: if (drv_lo) cnt++;
                   else if (drv_hi) begin p_low = cnt; ph = 4; end
                4: if (!line_oe) ph = 5;
                default: ph = 0;
            endcase
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;
        rst_n       = 1'b0;
        slave_low   = 1'b0;
        cycle_req   = 1'b0;
        quiet_sel   = 1'b0;
        start_width = SW_W'(4);
        frame_count = FC_W'(17);
        m_irq       = '0;
        m_ioc       = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset line_oe", int'(line_oe), 0);
        chk("R1 reset quiet_mode", int'(quiet_mode), 0);
        chk("R1 reset irq_level", int'(irq_level), 0);
        chk("R1 reset iochck_level", int'(iochck_level), 0);
        rst_n = 1'b1;
        // Continuous cycles, the second selecting Quiet mode.
        run_cycle(0, 24'h01_8005, 1'b0, 4, 17);
        run_cycle(0, 24'h00_F0F0, 1'b1, 8, 17);
        // Quiet idle with no request must stay released (R5).
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (line_oe) seen++;
        end
        chk("R5 quiet idle line_oe clocks", seen, 0);
        chk("R5 quiet idle irq_level held", int'(irq_level), int'(m_irq));
        // Slave-started short cycle: slots 10 and up keep their values.
        run_cycle(1, 24'h00_0321, 1'b1, 6, 10);
        // Local request held through the cycle (R10), clamped start.
        run_cycle(2, 24'h1F_0001, 1'b1, 2, 20);
        // Slave start, width clamp high, one frame, back to Continuous.
        run_cycle(1, 24'h00_0000, 1'b0, 15, 0);
        // Frame count above the maximum, then a final Quiet stop.
        run_cycle(0, 24'hAA_5A5A, 1'b0, 5, 30);
        run_cycle(0, 24'h00_8001, 1'b1, 7, 17);
        repeat (6) @(negedge clk);
        chk("R6 all queued cycles completed", exp_q.size(), 0);
        chk("R5 final quiet idle line_oe", int'(line_oe), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule